// File: doc/BRIEF.md
# Command Packet Header Decoder

This block turns a stream of 32-bit command words into two kinds of downstream traffic: register writes (an index plus a data word) and opcode transfers (an 8-bit opcode plus its body words). Each packet begins with a header word. The two top bits of the header pick one of four packet classes. The decoder then routes the body words that follow to the matching output channel. A filler class carries no body. A paired class writes two independent register indices, one after the other.

All three edges use valid/ready handshakes. Body words pass straight through without buffering, so a stalled downstream channel stalls the input. While the block waits for a header, it accepts a word whatever its output channels are doing.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: After reset, `in_ready` is 1 and both `wr_valid` and `op_valid` are 0.
- R2: Header bits 31:30 pick the class: 00 burst write, 01 paired write, 10 filler, 11 opcode. A filler header (10) is consumed without any output, and the next word is taken as a header.
- R3: A burst header (00) carries a count in bits 29:16 and a start index in bits 10:0. The next count+1 words are written to the start index, then start+1, and so on, with the index wrapping modulo 2048.
- R4: A paired header (01) takes its first index from bits 10:0 and its second index from bits 21:11. Exactly two body words follow, written to the first index and then the second.
- R5: An opcode header (11) carries the opcode in bits 15:8 and a count in bits 29:16. The next count+1 words appear on `op_data`, each with that opcode on `op_code`.
- R6: `op_start` is 1 only on the first body word of an opcode packet, and `op_last` is 1 only on its last body word.
- R7: While a body word is offered and the target channel is not ready, `in_ready` is 0 and the index, opcode and start flag hold their values. No word is lost.
- R8: The decoder returns to header wait only once the last body word has been accepted. In header wait, `in_ready` is 1 even with both downstream readies low.
- R9: `wr_valid` and `op_valid` are never 1 in the same cycle.
- R10: A body word whose top bits look like a header is passed on as data and is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle when in_valid is also 1 |
| in_dword | input | 32 | Command word |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_index | output | 11 | Register dword index |
| wr_data | output | 32 | Register write data |
| op_valid | output | 1 | Opcode body word offered |
| op_ready | input | 1 | Opcode body word accepted |
| op_code | output | 8 | Opcode of the current packet |
| op_data | output | 32 | Opcode body word |
| op_start | output | 1 | First body word of the packet |
| op_last | output | 1 | Last body word of the packet |

## Verification
A corrupted state register shows up in the very next offered word. A body word gets decoded as a header, or a header gets emitted as a write, so the channel valids or `in_ready` come out wrong in that cycle. A wrong remaining count does not show at once. It appears at the packet boundary: `op_last` comes early or late, or the word after the body goes to the wrong channel. An index that fails to step or wrap shows on the second write of a burst. For this reason the vectors include bodies with words that look like headers, a wrap at the top index, and single-word packets.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    PK_BURST = 2'b00,
    PK_PAIR  = 2'b01,
    PK_FILL  = 2'b10,
    PK_OPC   = 2'b11
  } pkt_kind_e;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_BURST,
    ST_PAIR_A,
    ST_PAIR_B,
    ST_OPC
  } seq_state_e;
endpackage

// File: rtl/cpd_rst_sync.sv
module cpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cpd_hdr_fields.sv
module cpd_hdr_fields
  import cpd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 11,
  parameter int CNT_W = 14,
  parameter int OPC_W = 8
) (
  input  logic [DW-1:0]    hdr,
  output pkt_kind_e        kind,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] idx_a,
  output logic [IDX_W-1:0] idx_b,
  output logic [OPC_W-1:0] opcode
);
  localparam int OPC_LSB = 8;

  assign kind   = pkt_kind_e'(hdr[DW-1 -: 2]);
  assign count  = hdr[DW-3 -: CNT_W];
  assign idx_a  = hdr[IDX_W-1:0];
  assign idx_b  = hdr[2*IDX_W-1:IDX_W];
  assign opcode = hdr[OPC_LSB +: OPC_W];
endmodule

// File: rtl/cpd_seq.sv
module cpd_seq
  import cpd_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int CNT_W = 14,
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  pkt_kind_e        h_kind,
  input  logic [CNT_W-1:0] h_count,
  input  logic [IDX_W-1:0] h_idx_a,
  input  logic [IDX_W-1:0] h_idx_b,
  input  logic [OPC_W-1:0] h_opcode,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [IDX_W-1:0] wr_index,
  output logic             op_valid,
  input  logic             op_ready,
  output logic [OPC_W-1:0] op_code,
  output logic             op_start,
  output logic             op_last
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx2_q, idx2_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OPC_W-1:0] opc_q, opc_d;
  logic             first_q, first_d;
  logic             cnt_zero, fire, upd_en;

  assign cnt_zero = (cnt_q == '0);
  assign fire     = in_valid && in_ready;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx2_d   = idx2_q;
    cnt_d    = cnt_q;
    opc_d    = opc_q;
    first_d  = first_q;
    in_ready = 1'b0;
    wr_valid = 1'b0;
    op_valid = 1'b0;
    upd_en   = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        in_ready = 1'b1;
        upd_en   = in_valid;
        unique case (h_kind)
          PK_BURST: begin state_d = ST_BURST;  idx_d = h_idx_a; cnt_d = h_count; end
          PK_PAIR:  begin state_d = ST_PAIR_A; idx_d = h_idx_a; idx2_d = h_idx_b; end
          PK_OPC:   begin state_d = ST_OPC;    opc_d = h_opcode; cnt_d = h_count; first_d = 1'b1; end
          default:  state_d = ST_HDR;
        endcase
      end
      ST_BURST: begin
        wr_valid = in_valid;
        in_ready = wr_ready;
        upd_en   = fire;
        idx_d    = idx_q + 1'b1;
        cnt_d    = cnt_q - 1'b1;
        state_d  = cnt_zero ? ST_HDR : ST_BURST;
      end
      ST_PAIR_A: begin
        wr_valid = in_valid;
        in_ready = wr_ready;
        upd_en   = fire;
        idx_d    = idx2_q;
        state_d  = ST_PAIR_B;
      end
      ST_PAIR_B: begin
        wr_valid = in_valid;
        in_ready = wr_ready;
        upd_en   = fire;
        state_d  = ST_HDR;
      end
      ST_OPC: begin
        op_valid = in_valid;
        in_ready = op_ready;
        upd_en   = fire;
        cnt_d    = cnt_q - 1'b1;
        first_d  = 1'b0;
        state_d  = cnt_zero ? ST_HDR : ST_OPC;
      end
      default: begin
        upd_en  = 1'b1;
        state_d = ST_HDR;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      idx_q   <= '0;
      idx2_q  <= '0;
      cnt_q   <= '0;
      opc_q   <= '0;
      first_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      idx2_q  <= idx2_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      first_q <= first_d;
    end
  end

  assign wr_index = idx_q;
  assign op_code  = opc_q;
  assign op_start = (state_q == ST_OPC) && first_q;
  assign op_last  = (state_q == ST_OPC) && cnt_zero;

  // R9
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, op_valid}));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_index));

  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> ($stable(op_code) && $stable(op_start)));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST && wr_valid && wr_ready && !cnt_zero)
      |=> (wr_index == IDX_W'($past(wr_index) + 1'b1)));

  // R6
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_last) |=> !op_start);
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import cpd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 11,
  parameter int CNT_W = 14,
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_dword,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [IDX_W-1:0] wr_index,
  output logic [DW-1:0]    wr_data,
  output logic             op_valid,
  input  logic             op_ready,
  output logic [OPC_W-1:0] op_code,
  output logic [DW-1:0]    op_data,
  output logic             op_start,
  output logic             op_last
);
  logic             rst_sync_n;
  pkt_kind_e        h_kind;
  logic [CNT_W-1:0] h_count;
  logic [IDX_W-1:0] h_idx_a, h_idx_b;
  logic [OPC_W-1:0] h_opcode;

  cpd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpd_hdr_fields #(.DW(DW), .IDX_W(IDX_W), .CNT_W(CNT_W), .OPC_W(OPC_W)) u_fields (
    .hdr    (in_dword),
    .kind   (h_kind),
    .count  (h_count),
    .idx_a  (h_idx_a),
    .idx_b  (h_idx_b),
    .opcode (h_opcode)
  );

  cpd_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W), .OPC_W(OPC_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .h_kind   (h_kind),
    .h_count  (h_count),
    .h_idx_a  (h_idx_a),
    .h_idx_b  (h_idx_b),
    .h_opcode (h_opcode),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_index (wr_index),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_code  (op_code),
    .op_start (op_start),
    .op_last  (op_last)
  );

  assign wr_data = in_dword;
  assign op_data = in_dword;

  // R2
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && !wr_valid && !op_valid && h_kind == PK_FILL)
      |=> (in_ready && !op_start));
endmodule

// File: tb/tb_cmd_pkt_decoder.sv
module tb_cmd_pkt_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_dword = '0;
  logic        wr_ready = 1'b1;
  logic        op_ready = 1'b1;
  logic        in_ready, wr_valid, op_valid, op_start, op_last;
  logic [10:0] wr_index;
  logic [31:0] wr_data, op_data;
  logic [7:0]  op_code;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmd_pkt_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dword(in_dword), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_index(wr_index), .wr_data(wr_data), .op_valid(op_valid),
    .op_ready(op_ready), .op_code(op_code), .op_data(op_data),
    .op_start(op_start), .op_last(op_last)
  );

  // {dword, kind(0 none,1 write,2 opcode), index, opcode, start, last}
  localparam int NV = 19;
  localparam logic [54:0] VEC [NV] = '{
    {32'h0001_0100, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R3 burst header
    {32'hDEAD_0001, 2'd1, 11'h100, 8'h00, 1'b0, 1'b0}, // R3
    {32'hDEAD_0002, 2'd1, 11'h101, 8'h00, 1'b0, 1'b0}, // R3
    {32'h8000_0000, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R2 filler
    {32'h403F_F805, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R4 paired header
    {32'hC000_0000, 2'd1, 11'h005, 8'h00, 1'b0, 1'b0}, // R4 R10
    {32'h1234_5678, 2'd1, 11'h7FF, 8'h00, 1'b0, 1'b0}, // R4
    {32'hC002_9B00, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R5 opcode header
    {32'h8000_0000, 2'd2, 11'h000, 8'h9B, 1'b1, 1'b0}, // R5 R6 R10
    {32'h0000_0011, 2'd2, 11'h000, 8'h9B, 1'b0, 1'b0}, // R5 R6
    {32'h0000_0022, 2'd2, 11'h000, 8'h9B, 1'b0, 1'b1}, // R6
    {32'hC000_2300, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R5 single body
    {32'hCAFE_F00D, 2'd2, 11'h000, 8'h23, 1'b1, 1'b1}, // R6
    {32'h0001_07FF, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R3 wrap header
    {32'h1111_1111, 2'd1, 11'h7FF, 8'h00, 1'b0, 1'b0}, // R3
    {32'h2222_2222, 2'd1, 11'h000, 8'h00, 1'b0, 1'b0}, // R3 wrap
    {32'h8000_0000, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R2
    {32'h0000_0003, 2'd0, 11'h000, 8'h00, 1'b0, 1'b0}, // R3 count 0
    {32'h4000_0001, 2'd1, 11'h003, 8'h00, 1'b0, 1'b0}  // R3 R10
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(in_ready && !wr_valid && !op_valid, "R1", {61'd0, in_ready, wr_valid, op_valid}, 64'd4);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(in_ready && !wr_valid && !op_valid, "R1", {61'd0, in_ready, wr_valid, op_valid}, 64'd4);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] dw;
      logic [1:0]  k;
      logic [63:0] a, e;
      @(negedge clk);
      dw = VEC[i][54:23];
      k  = VEC[i][22:21];
      in_valid = 1'b1;
      in_dword = dw;
      #1;
      e = {8'd0, 1'b1, k == 2'd1, k == 2'd2, VEC[i][20:10], VEC[i][9:2],
           (k != 2'd0) ? dw : 32'd0, VEC[i][1], VEC[i][0]};
      a = {8'd0, in_ready, wr_valid, op_valid,
           (k == 2'd1) ? wr_index : 11'd0,
           (k == 2'd2) ? op_code : 8'd0,
           (k == 2'd1) ? wr_data : ((k == 2'd2) ? op_data : 32'd0),
           (k == 2'd2) ? op_start : 1'b0,
           (k == 2'd2) ? op_last : 1'b0};
      check(a == e, $sformatf("R2-R10 vec%0d R9", i), a, e);
      @(posedge clk);
    end

    // R8: header accepted with both readies low
    @(negedge clk);
    wr_ready = 1'b0; op_ready = 1'b0;
    in_dword = 32'h0000_0010;
    #1 check(in_ready && !wr_valid, "R8", {62'd0, in_ready, wr_valid}, 64'd2);
    @(posedge clk);
    // R7: body stalls
    @(negedge clk);
    in_dword = 32'h0000_ABCD;
    #1 check(!in_ready && wr_valid && wr_index == 11'h010, "R7",
             {51'd0, in_ready, wr_valid, wr_index}, {51'd0, 2'b01, 11'h010});
    @(posedge clk);
    @(negedge clk);
    #1 check(!in_ready && wr_valid && wr_index == 11'h010 && wr_data == 32'h0000_ABCD, "R7",
             {51'd0, in_ready, wr_valid, wr_index}, {51'd0, 2'b01, 11'h010});
    wr_ready = 1'b1;
    #1 check(in_ready, "R7", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    // R8: back in header wait after last body accepted
    @(negedge clk);
    wr_ready = 1'b0;
    in_dword = 32'h8000_0000;
    #1 check(in_ready && !wr_valid && !op_valid, "R8", {61'd0, in_ready, wr_valid, op_valid}, 64'd4);
    @(posedge clk);

    // R7 R6: opcode stall
    @(negedge clk);
    in_dword = 32'hC001_9A00;
    @(posedge clk);
    @(negedge clk);
    in_dword = 32'h0000_0055;
    #1 check(!in_ready && op_valid && op_start && op_code == 8'h9A, "R7 R6",
             {53'd0, in_ready, op_valid, op_start, op_code}, {53'd0, 3'b011, 8'h9A});
    @(posedge clk);
    @(negedge clk);
    #1 check(!in_ready && op_valid && op_start && !op_last, "R7 R6",
             {60'd0, in_ready, op_valid, op_start, op_last}, 64'b0110);
    op_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_dword = 32'h0000_0066;
    #1 check(op_valid && !op_start && op_last && op_data == 32'h66, "R6",
             {61'd0, op_valid, op_start, op_last}, 64'b101);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wr_ready = 1'b1;
    #1 check(in_ready && !op_valid && !wr_valid, "R8", {61'd0, in_ready, wr_valid, op_valid}, 64'd4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule